// File: doc/BRIEF.md
# Flash sector protection lock controller

This block holds the write-protection state of a serial flash part. It keeps one protection flag per sector and a single lock flag, and it decides whether each decoded command is allowed to change them. The command decoder in front of it sends one-cycle strobes: protect one sector, unprotect one sector, or write the status byte. Each strobe comes with a sector index or a data byte. The block also samples an active-low write-protect pin. An erase or program engine reads the per-sector flags; a status read returns the formatted status byte.

The lock flag is held by a two-state machine. `ST_OPEN` means the lock flag is 0 and `ST_LOCKED` means it is 1. Two transitions are named. `T_SET_LOCK` goes from `ST_OPEN` to `ST_LOCKED` on a status write with bit 7 set, and the pin level does not matter. `T_CLEAR_LOCK` goes from `ST_LOCKED` to `ST_OPEN` on a status write with bit 7 clear, and only while the pin is high. Software lock means `ST_LOCKED` with the pin high. Hardware lock means `ST_LOCKED` with the pin low. While the pin is held low, only a reset leaves `ST_LOCKED`. A status write made in `ST_OPEN` may also protect or unprotect every sector in the same operation, through bits 5 down to 2. No status write made in `ST_LOCKED` touches the sector flags.

Top module: `flash_prot_lock`

## Requirements
- R1: Reset (active-low `rst_n`) sets every sector flag to 1 (protected) and clears the lock flag to 0.
- R2: While the lock flag is 0, a protect strobe sets the flag of sector `sect_idx` and an unprotect strobe clears it, and no other sector changes. If both strobes come in the same cycle, protect wins.
- R3: While the lock flag is 0, a status write copies data bit 7 into the lock flag. Data bits 5..2 equal to 1111 set every sector flag, 0000 clears every sector flag, and any other value leaves the sector flags unchanged. Setting the lock and applying the global pattern happen in the same write.
- R4: While the lock flag is 1, protect and unprotect strobes leave every sector flag unchanged, at either pin level.
- R5: With the lock flag 1 and `wp_n` high, a status write with bit 7 = 0 clears the lock flag. The sector flags stay unchanged in that write, whatever bits 5..2 hold.
- R6: With the lock flag 1 and `wp_n` low, every status write is ignored, so the lock flag stays 1 until reset and the sector flags do not change.
- R7: With the lock flag 1 and `wp_n` high, a status write with bit 7 = 1 changes nothing.
- R8: `status` bit 7 shows the lock flag and bit 4 shows the `wp_n` level. Bits 3..2 show the protection summary: 11 when all sectors are protected, 01 when some are, 00 when none are. All other bits read 0.
- R9: A status write in the same cycle as a protect or unprotect strobe takes priority, and the sector strobe is dropped.
- R10: Every accepted command shows on the outputs after the next rising clock edge. After a lock clear, sector commands take effect again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wp_n | input | 1 | Write-protect pin, asserted low |
| prot_stb | input | 1 | Protect-sector command strobe |
| unprot_stb | input | 1 | Unprotect-sector command strobe |
| sect_idx | input | $clog2(NUM_SECT) | Sector addressed by a protect or unprotect strobe |
| wrsr_stb | input | 1 | Status-write command strobe |
| wrsr_data | input | 8 | Status-write data byte |
| sect_prot | output | NUM_SECT | Per-sector protection flags, 1 = protected |
| lock_bit | output | 1 | Lock flag |
| status | output | 8 | Formatted status byte |

## Verification
If the lock state is wrong, `status` bit 7 shows it one edge after the faulty command. The next protect, unprotect or status write then goes to the wrong side, and `sect_prot` shows that in the following cycle. If a sector flag is wrong, it shows directly on `sect_prot` and in the summary bits 3..2 after the same edge. Wrong command priority or a global pattern applied at the wrong time shows as a flag pattern that differs from the expected one right after that single write.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;

    typedef enum logic [1:0] {
        SUM_NONE = 2'b00,
        SUM_SOME = 2'b01,
        SUM_ALL  = 2'b11
    } prot_sum_t;

    localparam int LOCK_BIT_POS = 7;
    localparam int PIN_BIT_POS  = 4;
    localparam int GLOB_HI      = 5;
    localparam int GLOB_LO      = 2;
endpackage

// File: rtl/fpl_lock_fsm.sv
module fpl_lock_fsm
    import fpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wp_n,
    input  logic wrsr_stb,
    input  logic wrsr_lock,
    output logic lock_q,
    output logic single_ok,
    output logic glob_ok
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (wrsr_stb && wrsr_lock)          state_d = ST_LOCKED; // T_SET_LOCK
            ST_LOCKED: if (wrsr_stb && wp_n && !wrsr_lock) state_d = ST_OPEN;   // T_CLEAR_LOCK
            default:   state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        lock_q    = 1'b0;
        single_ok = 1'b0;
        glob_ok   = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                single_ok = !wrsr_stb;
                glob_ok   = wrsr_stb;
            end
            ST_LOCKED: lock_q = 1'b1;
            default: ;
        endcase
    end

    // R6
    hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !wp_n) |=> lock_q);

    // R5
    clear_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(wp_n));
endmodule

// File: rtl/fpl_sect_bank.sv
module fpl_sect_bank
    import fpl_pkg::*;
#(
    parameter int NUM_SECT = 16,
    localparam int IDX_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_q,
    input  logic                single_ok,
    input  logic                glob_ok,
    input  logic                prot_stb,
    input  logic                unprot_stb,
    input  logic [IDX_W-1:0]    sect_idx,
    input  logic [7:0]          wrsr_data,
    output logic [NUM_SECT-1:0] prot_q
);
    localparam int GLOB_W = GLOB_HI - GLOB_LO + 1;

    logic glob_set, glob_clr;

    always_comb begin
        glob_set = glob_ok && (wrsr_data[GLOB_HI:GLOB_LO] == {GLOB_W{1'b1}});
        glob_clr = glob_ok && (wrsr_data[GLOB_HI:GLOB_LO] == {GLOB_W{1'b0}});
    end

    generate
        for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
            logic hit;
            assign hit = single_ok && (sect_idx == IDX_W'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  prot_q[i] <= 1'b1;
                else if (glob_set)           prot_q[i] <= 1'b1;
                else if (glob_clr)           prot_q[i] <= 1'b0;
                else if (hit && prot_stb)    prot_q[i] <= 1'b1;
                else if (hit && unprot_stb)  prot_q[i] <= 1'b0;
            end
        end
    endgenerate

    // R4
    locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(prot_q));

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_stb && !unprot_stb && !wrsr_stb_seen()) |=> $stable(prot_q));

    function automatic logic wrsr_stb_seen();
        return glob_ok;
    endfunction
endmodule

// File: rtl/fpl_stat_pack.sv
module fpl_stat_pack
    import fpl_pkg::*;
#(
    parameter int NUM_SECT = 16
) (
    input  logic [NUM_SECT-1:0] prot_q,
    input  logic                lock_q,
    input  logic                wp_n,
    output logic [7:0]          status
);
    prot_sum_t sum;

    always_comb begin
        if (&prot_q)      sum = SUM_ALL;
        else if (|prot_q) sum = SUM_SOME;
        else              sum = SUM_NONE;
        status                  = 8'h00;
        status[LOCK_BIT_POS]    = lock_q;
        status[PIN_BIT_POS]     = wp_n;
        status[GLOB_HI-2:GLOB_LO] = sum;
    end
endmodule

// File: rtl/flash_prot_lock.sv
module flash_prot_lock
    import fpl_pkg::*;
#(
    parameter int NUM_SECT = 16,
    localparam int IDX_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wp_n,
    input  logic                prot_stb,
    input  logic                unprot_stb,
    input  logic [IDX_W-1:0]    sect_idx,
    input  logic                wrsr_stb,
    input  logic [7:0]          wrsr_data,
    output logic [NUM_SECT-1:0] sect_prot,
    output logic                lock_bit,
    output logic [7:0]          status
);
    logic lock_q, single_ok, glob_ok;

    fpl_lock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_n      (wp_n),
        .wrsr_stb  (wrsr_stb),
        .wrsr_lock (wrsr_data[LOCK_BIT_POS]),
        .lock_q    (lock_q),
        .single_ok (single_ok),
        .glob_ok   (glob_ok)
    );

    fpl_sect_bank #(.NUM_SECT(NUM_SECT)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_q     (lock_q),
        .single_ok  (single_ok),
        .glob_ok    (glob_ok),
        .prot_stb   (prot_stb),
        .unprot_stb (unprot_stb),
        .sect_idx   (sect_idx),
        .wrsr_data  (wrsr_data),
        .prot_q     (sect_prot)
    );

    fpl_stat_pack #(.NUM_SECT(NUM_SECT)) u_stat (
        .prot_q (sect_prot),
        .lock_q (lock_q),
        .wp_n   (wp_n),
        .status (status)
    );

    assign lock_bit = lock_q;

    // R9
    wrsr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_stb && !lock_q && wrsr_data[5:2] != 4'hF && wrsr_data[5:2] != 4'h0)
            |=> $stable(sect_prot));
endmodule

// File: tb/flash_prot_lock_test.sv
module flash_prot_lock_test;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          prot_stb = 1'b0, unprot_stb = 1'b0, wrsr_stb = 1'b0;
    logic [3:0]    sect_idx = '0;
    logic [7:0]    wrsr_data = '0;
    logic [N-1:0]  sect_prot;
    logic          lock_bit;
    logic [7:0]    status;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_prot_lock #(.NUM_SECT(N)) uut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .prot_stb(prot_stb), .unprot_stb(unprot_stb), .sect_idx(sect_idx),
        .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data),
        .sect_prot(sect_prot), .lock_bit(lock_bit), .status(status)
    );

    task automatic chk(string req, logic [N-1:0] ep, logic el, logic [7:0] es);
        n_run++;
        if (sect_prot !== ep || lock_bit !== el || status !== es) begin
            n_fail++;
            $display("FAIL %s: prot=%h lock=%b status=%h expected prot=%h lock=%b status=%h",
                     req, sect_prot, lock_bit, status, ep, el, es);
        end
    endtask

    task automatic cmd(logic p, logic u, logic [3:0] idx, logic w, logic [7:0] d);
        @(negedge clk);
        prot_stb = p; unprot_stb = u; sect_idx = idx; wrsr_stb = w; wrsr_data = d;
        @(negedge clk);
        prot_stb = 0; unprot_stb = 0; wrsr_stb = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        wp_n = 1;
        do_reset();
        chk("R1 reset", 16'hFFFF, 0, 8'h1C);
    endtask

    task automatic t_single();
        cmd(0, 1, 4'd3, 0, 8'h00);
        chk("R2 unprotect 3", 16'hFFF7, 0, 8'h14);
        cmd(0, 0, 4'd0, 1, 8'h00);
        chk("R3 global unprotect", 16'h0000, 0, 8'h10);
        cmd(1, 0, 4'd5, 0, 8'h00);
        chk("R2 protect 5", 16'h0020, 0, 8'h14);
        cmd(1, 1, 4'd9, 0, 8'h00);
        chk("R2 protect wins", 16'h0220, 0, 8'h14);
    endtask

    task automatic t_global();
        cmd(0, 0, 4'd0, 1, 8'h14);
        chk("R3 other pattern", 16'h0220, 0, 8'h14);
        cmd(0, 0, 4'd0, 1, 8'h3C);
        chk("R3 global protect", 16'hFFFF, 0, 8'h1C);
        cmd(0, 0, 4'd0, 1, 8'h80);
        chk("R3 lock plus global unprotect", 16'h0000, 1, 8'h90);
    endtask

    task automatic t_soft_lock();
        cmd(1, 0, 4'd2, 0, 8'h00);
        chk("R4 protect ignored", 16'h0000, 1, 8'h90);
        cmd(0, 0, 4'd0, 1, 8'hBC);
        chk("R7 locked rewrite", 16'h0000, 1, 8'h90);
        cmd(0, 0, 4'd0, 1, 8'h3C);
        chk("R5 clear lock no global", 16'h0000, 0, 8'h10);
        cmd(1, 0, 4'd1, 0, 8'h00);
        chk("R10 sector cmd after clear", 16'h0002, 0, 8'h14);
    endtask

    task automatic t_hw_lock();
        cmd(0, 0, 4'd0, 1, 8'hBC);
        chk("R3 set lock global protect", 16'hFFFF, 1, 8'h9C);
        @(negedge clk); wp_n = 0;
        @(negedge clk);
        chk("R8 pin low status", 16'hFFFF, 1, 8'h8C);
        cmd(0, 0, 4'd0, 1, 8'h00);
        chk("R6 write ignored", 16'hFFFF, 1, 8'h8C);
        cmd(0, 1, 4'd0, 0, 8'h00);
        chk("R4 unprotect ignored", 16'hFFFF, 1, 8'h8C);
        do_reset();
        chk("R6 reset clears lock", 16'hFFFF, 0, 8'h0C);
    endtask

    task automatic t_priority();
        cmd(0, 1, 4'd7, 1, 8'h14);
        chk("R9 status write wins", 16'hFFFF, 0, 8'h0C);
        cmd(0, 1, 4'd7, 0, 8'h00);
        chk("R8 some protected", 16'hFF7F, 0, 8'h04);
    endtask

    initial begin
        t_reset();
        t_single();
        t_global();
        t_soft_lock();
        t_hw_lock();
        t_priority();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule